// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block models a pipelined synchronous static memory that defers every write. A command (address plus an operation code) is taken on a rising clock edge. For a write, the data follows one cycle later. That address and data pair is then parked in a small holding buffer. It reaches the storage array only when the next write's data is captured. A read takes its address on one edge and returns registered data on the next edge. When a read beat targets an address that is still parked in the holding buffer, the data is taken from the buffer instead of the array.

Each access moves either one beat (single-rate) or two beats (double-rate). The two double-rate beats travel side by side on a bus of twice the word width: the low half carries the beat of the rising edge and the high half carries the beat of the falling edge. Bursts step the low two address bits in linear or interleaved order, over a length of 1, 2 or 4 beats. A continue operation advances the burst. A write-type command issued straight after a read-type access raises a one-cycle turnaround flag.

Top module: `lw_sram`

## Requirements
- R1: While reset is asserted and after it, until the first read, `rdata_o`, `rvalid_o` and `turn_err_o` are 0, the holding buffer is empty and every array word reads as 0.
- R2: `op_i` is sampled on the rising edge, encoded 00 = no-op, 01 = read, 10 = write, 11 = continue. `rvalid_o` is 1 in exactly the cycle after a read-type access is sampled, and `rdata_o` updates only then.
- R3: Write data is sampled on `wdata_i` at the rising edge one cycle after its write-type command. Beat 0 is in bits [DW-1:0] and, in double-rate mode, beat 1 is in bits [2*DW-1:DW].
- R4: A write is committed to the array only when the data of the next write-type access is captured. A later read of that address, after the buffer has moved on, returns the committed data.
- R5: A read beat whose address matches a valid holding-buffer entry returns the buffered data. The match is checked for each beat separately.
- R6: A read issued before any write since reset never takes data from the buffer.
- R7: A single-rate read returns its beat in bits [DW-1:0] with the upper half 0. A double-rate read returns beat 0 in the low half and beat 1 in the high half.
- R8: With `lin_i` = 1, the low two bits of beat k are (base + k) mod 4. With `lin_i` = 0, they are base XOR k.
- R9: `blen_i` 00 selects 1 beat, 01 selects 2 beats, 10 or 11 selects 4 beats. A double-rate burst is at least 2 beats long, and the beat index wraps modulo the length.
- R10: Continue advances the beat index by 1 (single-rate) or 2 (double-rate) and keeps the direction, mode and base latched by the last read or write. Continue before any read or write since reset has no effect.
- R11: `turn_err_o` is 1 for one cycle after a write-type command is sampled while the current access is read-type. The write is still performed.
- R12: Every beat of a burst keeps the address bits above bit 1 of the base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 2 | Operation code |
| addr_i | input | AW | Start address for read or write |
| ddr_i | input | 1 | 1 = two beats per access |
| lin_i | input | 1 | 1 = linear burst order, 0 = interleaved |
| blen_i | input | 2 | Burst length code |
| wdata_i | input | 2*DW | Write data, one cycle after the command |
| rdata_o | output | 2*DW | Registered read data |
| rvalid_o | output | 1 | Read data valid |
| turn_err_o | output | 1 | Read-to-write turnaround violation |

## Verification
On every cycle, the assertions check the timing links: read valid follows a read access, the turnaround flag follows a read access, commits happen only in write data phases, buffered data reaches the output on a hit, and the two beats of a double-rate access are distinct and share their upper address bits. Whether the correct data value arrives after a chain of deferred commits, burst wrapping and mode changes can only be shown by the bench's scenarios. The bench checks these against its behavioural reference model over directed sequences and a long random mix.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_CONT  = 2'b11
  } op_e;

  // low address bits of a burst beat
  function automatic logic [1:0] beat_low(input logic [1:0] base,
                                          input logic [1:0] idx,
                                          input logic       lin);
    return lin ? (base + idx) : (base ^ idx);
  endfunction

  // burst length as wrap mask, double-rate needs at least two beats
  function automatic logic [1:0] len_mask(input logic [1:0] code,
                                          input logic       ddr);
    logic [1:0] m;
    case (code)
      2'b00:   m = 2'b00;
      2'b01:   m = 2'b01;
      default: m = 2'b11;
    endcase
    if (ddr && (m == 2'b00)) m = 2'b01;
    return m;
  endfunction

endpackage

// File: rtl/lw_rst_sync.sv
module lw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n_s = sh_q[1];
endmodule

// File: rtl/lw_burst_seq.sv
module lw_burst_seq
  import lw_sram_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         op_i,
  input  logic [AW-1:0]      addr_i,
  input  logic               ddr_i,
  input  logic               lin_i,
  input  logic [1:0]         blen_i,
  output logic               acc_v,
  output logic               acc_wr,
  output logic               acc_ddr,
  output logic [1:0][AW-1:0] beat_a,
  output logic               wr_issue
);
  op_e           op;
  logic          act_q, act_d;
  logic          wr_q, wr_d;
  logic          ddr_q, ddr_d;
  logic          lin_q, lin_d;
  logic [1:0]    mask_q, mask_d;
  logic [AW-1:0] base_q, base_d;
  logic [1:0]    k_q, k_d;
  logic          accv_q, accv_d;
  logic [1:0]    k1;

  assign op = op_e'(op_i);

  always_comb begin
    act_d  = act_q;
    wr_d   = wr_q;
    ddr_d  = ddr_q;
    lin_d  = lin_q;
    mask_d = mask_q;
    base_d = base_q;
    k_d    = k_q;
    accv_d = 1'b0;
    case (op)
      OP_READ, OP_WRITE: begin
        act_d  = 1'b1;
        wr_d   = (op == OP_WRITE);
        ddr_d  = ddr_i;
        lin_d  = lin_i;
        mask_d = len_mask(blen_i, ddr_i);
        base_d = addr_i;
        k_d    = 2'd0;
        accv_d = 1'b1;
      end
      OP_CONT: begin
        if (act_q) begin
          k_d    = (k_q + (ddr_q ? 2'd2 : 2'd1)) & mask_q;
          accv_d = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      ddr_q  <= 1'b0;
      lin_q  <= 1'b0;
      mask_q <= 2'b00;
      base_q <= '0;
      k_q    <= 2'd0;
      accv_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      wr_q   <= wr_d;
      ddr_q  <= ddr_d;
      lin_q  <= lin_d;
      mask_q <= mask_d;
      base_q <= base_d;
      k_q    <= k_d;
      accv_q <= accv_d;
    end
  end

  assign k1        = (k_q + 2'd1) & mask_q;
  assign beat_a[0] = {base_q[AW-1:2], beat_low(base_q[1:0], k_q, lin_q)};
  assign beat_a[1] = {base_q[AW-1:2], beat_low(base_q[1:0], k1, lin_q)};
  assign acc_v     = accv_q;
  assign acc_wr    = wr_q;
  assign acc_ddr   = ddr_q;
  assign wr_issue  = (op == OP_WRITE) || ((op == OP_CONT) && act_q && wr_q);
endmodule

// File: rtl/lw_hold_buf.sv
module lw_hold_buf #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_en,
  input  logic               cap_ddr,
  input  logic [1:0][AW-1:0] cap_a,
  input  logic [2*DW-1:0]    cap_d,
  input  logic [1:0][AW-1:0] lk_a,
  output logic [1:0]         hit,
  output logic [1:0][DW-1:0] hdat,
  output logic [1:0]         cm_we,
  output logic [1:0][AW-1:0] cm_a,
  output logic [1:0][DW-1:0] cm_d
);
  logic [1:0]          hv_q, hv_d;
  logic [1:0][AW-1:0]  ha_q, ha_d;
  logic [1:0][DW-1:0]  hd_q, hd_d;

  always_comb begin
    hv_d = hv_q;
    ha_d = ha_q;
    hd_d = hd_q;
    if (cap_en) begin
      ha_d    = cap_a;
      hd_d[0] = cap_d[DW-1:0];
      hd_d[1] = cap_d[2*DW-1:DW];
      hv_d    = {cap_ddr, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_q <= 2'b00;
      ha_q <= '0;
      hd_q <= '0;
    end else begin
      hv_q <= hv_d;
      ha_q <= ha_d;
      hd_q <= hd_d;
    end
  end

  // commit the older pair when the next write data lands
  assign cm_we = cap_en ? hv_q : 2'b00;
  assign cm_a  = ha_q;
  assign cm_d  = hd_q;

  for (genvar j = 0; j < 2; j++) begin : g_lookup
    logic m0, m1;
    assign m0      = hv_q[0] && (ha_q[0] == lk_a[j]);
    assign m1      = hv_q[1] && (ha_q[1] == lk_a[j]);
    assign hit[j]  = m0 || m1;
    assign hdat[j] = m1 ? hd_q[1] : hd_q[0];
  end
endmodule

// File: rtl/lw_array.sv
module lw_array #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         we,
  input  logic [1:0][AW-1:0] wa,
  input  logic [1:0][DW-1:0] wd,
  input  logic [1:0][AW-1:0] ra,
  output logic [1:0][DW-1:0] rd
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (we[p]) mem_q[wa[p]] <= wd[p];
      end
    end
  end

  for (genvar j = 0; j < 2; j++) begin : g_rd
    assign rd[j] = mem_q[ra[j]];
  end
endmodule

// File: rtl/lw_sram.sv
module lw_sram #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      op_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            ddr_i,
  input  logic            lin_i,
  input  logic [1:0]      blen_i,
  input  logic [2*DW-1:0] wdata_i,
  output logic [2*DW-1:0] rdata_o,
  output logic            rvalid_o,
  output logic            turn_err_o
);
  localparam int BW = 2 * DW;

  logic               rst_n_s;
  logic               acc_v, acc_wr, acc_ddr, wr_issue;
  logic [1:0][AW-1:0] beat_a;
  logic [1:0]         hit;
  logic [1:0][DW-1:0] hdat, mdat, bdat;
  logic [1:0]         cm_we;
  logic [1:0][AW-1:0] cm_a;
  logic [1:0][DW-1:0] cm_d;
  logic               rd_acc;
  logic [BW-1:0]      rdata_q, rdata_d;
  logic               rvalid_q, err_q;

  lw_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  lw_burst_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .op_i(op_i), .addr_i(addr_i),
    .ddr_i(ddr_i), .lin_i(lin_i), .blen_i(blen_i),
    .acc_v(acc_v), .acc_wr(acc_wr), .acc_ddr(acc_ddr),
    .beat_a(beat_a), .wr_issue(wr_issue)
  );

  lw_hold_buf #(.AW(AW), .DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n_s), .cap_en(acc_v && acc_wr),
    .cap_ddr(acc_ddr), .cap_a(beat_a), .cap_d(wdata_i),
    .lk_a(beat_a), .hit(hit), .hdat(hdat),
    .cm_we(cm_we), .cm_a(cm_a), .cm_d(cm_d)
  );

  lw_array #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n_s), .we(cm_we), .wa(cm_a), .wd(cm_d),
    .ra(beat_a), .rd(mdat)
  );

  assign rd_acc = acc_v && !acc_wr;

  for (genvar j = 0; j < 2; j++) begin : g_beat
    assign bdat[j] = hit[j] ? hdat[j] : mdat[j];
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_acc) rdata_d = {acc_ddr ? bdat[1] : {DW{1'b0}}, bdat[0]};
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= rd_acc;
      err_q    <= rd_acc && wr_issue;
    end
  end

  assign rdata_o    = rdata_q;
  assign rvalid_o   = rvalid_q;
  assign turn_err_o = err_q;
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input logic               clk,
  input logic               rst_n_s,
  input logic               acc_v,
  input logic               acc_wr,
  input logic               acc_ddr,
  input logic               wr_issue,
  input logic [1:0][AW-1:0] beat_a,
  input logic [1:0]         hit,
  input logic [1:0][DW-1:0] hdat,
  input logic [1:0]         cm_we,
  input logic [2*DW-1:0]    rdata_o,
  input logic               rvalid_o,
  input logic               turn_err_o
);
  // R2
  rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc_v && !acc_wr) |=> rvalid_o);
  // R2
  rvalid_source_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rvalid_o |-> $past(acc_v && !acc_wr));
  // R11
  turn_flag_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc_v && !acc_wr && wr_issue) |=> turn_err_o);
  // R11
  turn_source_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    turn_err_o |-> $past(acc_v && !acc_wr));
  // R5
  bypass_data_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc_v && !acc_wr && hit[0]) |=> (rdata_o[DW-1:0] == $past(hdat[0])));
  // R4
  commit_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cm_we != 2'b00) |-> (acc_v && acc_wr));
  // R9
  ddr_beats_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc_v && acc_ddr) |-> (beat_a[0] != beat_a[1]));
  // R12
  upper_bits_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    acc_v |-> (beat_a[0][AW-1:2] == beat_a[1][AW-1:2]));
  // R7
  sdr_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc_v && !acc_wr && !acc_ddr) |=> (rdata_o[2*DW-1:DW] == '0));
endmodule

bind lw_sram lw_sram_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .acc_v(acc_v), .acc_wr(acc_wr),
  .acc_ddr(acc_ddr), .wr_issue(wr_issue), .beat_a(beat_a), .hit(hit),
  .hdat(hdat), .cm_we(cm_we), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
  .turn_err_o(turn_err_o)
);

// File: tb/lw_sram_tb.sv
`timescale 1ns/1ps
module lw_sram_tb;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      op_i;
  logic [AW-1:0]   addr_i;
  logic            ddr_i, lin_i;
  logic [1:0]      blen_i;
  logic [2*DW-1:0] wdata_i;
  logic [2*DW-1:0] rdata_o;
  logic            rvalid_o, turn_err_o;

  always #2.5 clk = ~clk;

  lw_sram #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .addr_i(addr_i), .ddr_i(ddr_i),
    .lin_i(lin_i), .blen_i(blen_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .rvalid_o(rvalid_o), .turn_err_o(turn_err_o)
  );

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  string cur_tag = "R7";

  // reference model state
  int mem [DEPTH];
  int hold_a [2];
  int hold_d [2];
  bit hold_v [2];
  bit b_act = 0, b_wr = 0, b_ddr = 0, b_lin = 0;
  int b_len = 1, b_base = 0, b_k = 0;
  bit p_v = 0, p_wr = 0, p_ddr = 0;
  int p_a0 = 0, p_a1 = 0;
  bit e_rv = 0, e_err = 0;
  logic [2*DW-1:0] e_rd = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int addr_of(input int k);
    int lo = b_base % 4;
    int nl = b_lin ? (lo + k) % 4 : (lo ^ k);
    return (b_base / 4) * 4 + nl;
  endfunction

  function automatic int lookup(input int a);
    if (hold_v[1] && hold_a[1] == a) return hold_d[1];
    if (hold_v[0] && hold_a[0] == a) return hold_d[0];
    return mem[a];
  endfunction

  // compare current outputs, drive next inputs, advance model one edge
  task automatic step(input logic [1:0] op, input int a, input bit d,
                      input bit l, input int bl, input logic [2*DW-1:0] wd);
    chk("R2 rvalid", {31'b0, rvalid_o}, {31'b0, e_rv});
    chk("R11 turn_err", {31'b0, turn_err_o}, {31'b0, e_err});
    if (e_rv) chk({cur_tag, " rdata"}, {16'b0, rdata_o}, {16'b0, e_rd});
    op_i = op; addr_i = AW'(a); ddr_i = d; lin_i = l; blen_i = 2'(bl); wdata_i = wd;
    e_err = p_v && !p_wr && (op == 2'b10 || (op == 2'b11 && b_act && b_wr));
    e_rv  = p_v && !p_wr;
    if (e_rv) begin
      e_rd[DW-1:0]    = DW'(lookup(p_a0));
      e_rd[2*DW-1:DW] = p_ddr ? DW'(lookup(p_a1)) : '0;
    end
    if (p_v && p_wr) begin
      for (int i = 0; i < 2; i++) if (hold_v[i]) mem[hold_a[i]] = hold_d[i];
      hold_a[0] = p_a0; hold_d[0] = int'(wd[DW-1:0]);    hold_v[0] = 1;
      hold_a[1] = p_a1; hold_d[1] = int'(wd[2*DW-1:DW]); hold_v[1] = p_ddr;
    end
    if (op == 2'b01 || op == 2'b10) begin
      b_act = 1; b_wr = (op == 2'b10); b_ddr = d; b_lin = l; b_base = a; b_k = 0;
      b_len = (bl == 0) ? 1 : (bl == 1) ? 2 : 4;
      if (d && b_len == 1) b_len = 2;
      p_v = 1;
    end else if (op == 2'b11 && b_act) begin
      b_k = (b_k + (b_ddr ? 2 : 1)) % b_len;
      p_v = 1;
    end else begin
      p_v = 0;
    end
    p_wr = b_wr; p_ddr = b_ddr;
    p_a0 = addr_of(b_k); p_a1 = addr_of((b_k + 1) % b_len);
    @(negedge clk);
  endtask

  task automatic nop();
    step(2'b00, 0, 0, 0, 0, '0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 0;
    for (int i = 0; i < 2; i++) begin hold_a[i] = 0; hold_d[i] = 0; hold_v[i] = 0; end
    rst_n = 1'b0; op_i = 2'b00; addr_i = '0; ddr_i = 0; lin_i = 0; blen_i = 0; wdata_i = '0;
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    chk("R1 rdata in reset", {16'b0, rdata_o}, 32'h0);
    chk("R1 rvalid in reset", {31'b0, rvalid_o}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 turn_err after reset", {31'b0, turn_err_o}, 32'h0);

    // R10: continue before any burst does nothing
    cur_tag = "R10";
    step(2'b11, 0, 0, 1, 2, '0);
    step(2'b11, 0, 1, 1, 2, '0);
    nop(); nop();

    // R6: empty buffer, array reads zero (R1)
    cur_tag = "R6";
    step(2'b01, 5, 0, 1, 0, '0);
    step(2'b01, 6, 1, 0, 1, '0);
    nop(); nop();

    // R3 / R4 / R5: deferred writes then reads
    cur_tag = "R3";
    step(2'b10, 3, 0, 1, 0, '0);
    step(2'b00, 0, 0, 0, 0, 16'h00A5);
    cur_tag = "R5";
    step(2'b01, 3, 0, 1, 0, '0);
    nop(); nop();
    step(2'b10, 7, 0, 1, 0, '0);
    step(2'b10, 8, 0, 1, 0, 16'h003C);
    step(2'b00, 0, 0, 0, 0, 16'h0011);
    cur_tag = "R4";
    step(2'b01, 3, 0, 1, 0, '0);
    step(2'b01, 7, 0, 1, 0, '0);
    cur_tag = "R5";
    step(2'b01, 8, 0, 1, 0, '0);
    nop(); nop();

    // R8 / R9 / R7: double-rate linear burst of 4 with continue, read back interleaved
    cur_tag = "R8";
    step(2'b10, 9, 1, 1, 2, '0);
    step(2'b11, 0, 0, 0, 0, 16'h2211);
    step(2'b00, 0, 0, 0, 0, 16'h4433);
    cur_tag = "R7";
    step(2'b01, 9, 1, 0, 3, '0);
    cur_tag = "R9";
    step(2'b11, 0, 0, 0, 0, '0);
    step(2'b11, 0, 0, 0, 0, '0);
    cur_tag = "R12";
    step(2'b01, 11, 0, 1, 1, '0);
    step(2'b11, 0, 0, 0, 0, '0);
    step(2'b11, 0, 0, 0, 0, '0);
    nop();

    // R11: read followed straight by write
    cur_tag = "R11";
    step(2'b01, 2, 0, 1, 0, '0);
    step(2'b10, 2, 0, 1, 0, '0);
    step(2'b00, 0, 0, 0, 0, 16'h005A);
    step(2'b01, 2, 0, 1, 0, '0);
    nop(); nop();

    // mixed random traffic
    cur_tag = "R7";
    for (int n = 0; n < 4000; n++) begin
      step(2'($urandom % 4), int'($urandom % DEPTH), 1'($urandom % 2),
           1'($urandom % 2), int'($urandom % 4), 16'($urandom));
    end
    nop(); nop();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule